// File: doc/BRIEF.md
# Replaying First-In First-Out Buffer

This block is a 9-bit by 2048-word first-in first-out store. It is modelled in a single clock domain and driven by active-low strobe inputs. A high-to-low transition on the write strobe stores the word present on the data input. A high-to-low transition on the read strobe places the oldest unread word on the output register, which then holds that value until the next read.

Three active-low flags report the number of unread words: empty, half-full and full. A write made while full is dropped, and a read made while empty is dropped.

A rewind strobe moves the read position back to physical address zero and leaves the write position where it is. A block that has already been consumed can then be read again, as long as the write side has not passed the end of storage. A read strobe held low on an empty buffer waits for data. The next accepted word goes straight to the output and is never counted as stored.

Top module: `replay_fifo`

## Requirements
- R1: After reset, `dout` is 0, `empty_n` is 0, and `half_n` and `full_n` are 1. This holds whatever the buffer held before the reset.
- R2: A read acts on the clock edge that sees `rd_n` low after it was high. By the next sample point, `dout` shows the oldest unread word, in write order.
- R3: The flags are a function of the unread-word count N. For N=0, only `empty_n` is 0. For 1..1024, all flags are 1. For 1025..2047, only `half_n` is 0. For N=2048, `half_n` and `full_n` are 0.
- R4: `half_n` falls on the write that takes N from 1024 to 1025. It rises on the read that takes N from 1025 to 1024.
- R5: A write strobe while N=2048 leaves the stored words and the flags unchanged.
- R6: A read strobe while N=0, with no write in the same cycle, leaves `dout` and the flags unchanged.
- R7: A strobe held low for several cycles performs exactly one operation.
- R8: A falling edge on `rt_n` while `wr_n` and `rd_n` are both high moves the read position to address 0 and keeps the write position. N becomes the write position, and the flags follow from it.
- R9: A falling edge on `rt_n` while `rd_n` or `wr_n` is low has no effect on the read position.
- R10: If `rd_n` falls while N=0 and stays low, the next accepted write appears on `dout` and N stays 0. Further writes while `rd_n` is still low are stored normally and need a new read strobe.
- R11: A read and a write in the same cycle, with 0<N<2048, both take effect and N is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_n | input | 1 | Write strobe, active low, acts on its falling edge |
| rd_n | input | 1 | Read strobe, active low, acts on its falling edge |
| rt_n | input | 1 | Rewind strobe, active low, acts on its falling edge |
| din | input | 9 | Write data |
| dout | output | 9 | Last word read |
| empty_n | output | 1 | Low when no unread word remains |
| half_n | output | 1 | Low when more than half of storage is unread |
| full_n | output | 1 | Low when every location is unread |

## Verification
The bench steps occupancy across 1024/1025 and up to 2048. A design whose threshold is off by one would move the half-full flag one word early or late. A design that does not block writes when full would overwrite the oldest word, and the full read-back would show a wrong value.

After a completely full buffer is rewound, the full flag must come back. A count kept without the extra pointer bit would report the buffer as empty at that point.

A rewind is pulsed while a read strobe is held low, and a design that ignores the strobe guard would replay from zero. The flow-through sequence catches a design that counts the bypassed word as stored, and one that lets every later write reach the output.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  // strobe lane indices inside the edge detector
  localparam int unsigned STB_WR = 0;
  localparam int unsigned STB_RD = 1;
  localparam int unsigned STB_RT = 2;
  localparam int unsigned STB_N  = 3;

  typedef struct packed {
    logic empty_n;
    logic half_n;
    logic full_n;
  } fifo_flags_t;
endpackage

// File: rtl/replay_fifo_edge.sv
module replay_fifo_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      assign prev_d[g] = strobe_n[g];
      assign fall[g]   = prev_q[g] & ~strobe_n[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[g] <= 1'b1;
        else        prev_q[g] <= prev_d[g];
      end

      // R7
      single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall[g] |=> !fall[g]);
    end
  endgenerate
endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl #(
  parameter  int unsigned DEPTH = 2048,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          rt_fall,
  input  logic          wr_n,
  input  logic          rd_n,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          wr_en,
  output logic          rd_en,
  output logic          bypass,
  output logic [CW-1:0] count
);
  logic [CW-1:0] wp_q, wp_d;
  logic [CW-1:0] rp_q, rp_d;
  logic          ft_q, ft_d;
  logic          is_empty, is_full, rd_ok, ft_want, rewind;

  always_comb begin
    count    = wp_q - rp_q;
    is_empty = (count == '0);
    is_full  = (count == CW'(DEPTH));
    wr_en    = wr_fall & ~is_full;
    rd_ok    = rd_fall & ~is_empty;
    ft_want  = ft_q | (rd_fall & is_empty);
    bypass   = ft_want & wr_en & is_empty;
    rd_en    = rd_ok | bypass;
    rewind   = rt_fall & wr_n & rd_n;
    waddr    = wp_q[AW-1:0];
    raddr    = rp_q[AW-1:0];
  end

  always_comb begin
    wp_d = wp_q;
    if (wr_en) wp_d = wp_q + CW'(1);
    rp_d = rp_q;
    if (rewind)     rp_d = '0;
    else if (rd_en) rp_d = rp_q + CW'(1);
    ft_d = ft_q;
    if (rd_n || bypass)                       ft_d = 1'b0;
    else if (rd_fall && is_empty && !wr_en)   ft_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      ft_q <= 1'b0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      ft_q <= ft_d;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && wr_fall) |=> (wp_q == $past(wp_q)));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_fall && !wr_fall) |=> (rp_q == $past(rp_q)));
  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rp_q == '0 && wp_q == $past(wp_q)));
  // R9
  rewind_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_fall && (!wr_n || !rd_n) && !rd_en) |=> (rp_q == $past(rp_q)));
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem #(
  parameter  int unsigned WIDTH = 9,
  parameter  int unsigned DEPTH = 2048,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en,
  input  logic             bypass,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] dout_q, dout_d;

  always_ff @(posedge clk) begin
    if (wr_en) store[waddr] <= din;
  end

  always_comb begin
    dout_d = dout_q;
    if (rd_en) dout_d = bypass ? din : store[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

  // R10
  bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (dout_q == $past(din)));
endmodule

// File: rtl/replay_fifo_flags.sv
module replay_fifo_flags
  import replay_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH = 2048,
  localparam int unsigned CW    = $clog2(DEPTH) + 1,
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic [CW-1:0] count,
  output fifo_flags_t   flags
);
  always_comb begin
    flags.empty_n = (count != '0);
    flags.half_n  = ~(count > CW'(HALF));
    flags.full_n  = (count != CW'(DEPTH));
  end
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter  int unsigned WIDTH = 9,
  parameter  int unsigned DEPTH = 2048,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty_n,
  output logic             half_n,
  output logic             full_n
);
  logic [1:0]       rst_pipe;
  logic             rst_n_int;
  logic [STB_N-1:0] strobes_n, falls;
  logic [AW-1:0]    waddr, raddr;
  logic             wr_en, rd_en, bypass;
  logic [CW-1:0]    count;
  fifo_flags_t      flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  always_comb begin
    strobes_n         = '1;
    strobes_n[STB_WR] = wr_n;
    strobes_n[STB_RD] = rd_n;
    strobes_n[STB_RT] = rt_n;
  end

  replay_fifo_edge #(.N(STB_N)) u_edge (
    .clk(clk), .rst_n(rst_n_int), .strobe_n(strobes_n), .fall(falls));

  replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .wr_fall(falls[STB_WR]), .rd_fall(falls[STB_RD]), .rt_fall(falls[STB_RT]),
    .wr_n(wr_n), .rd_n(rd_n),
    .waddr(waddr), .raddr(raddr), .wr_en(wr_en), .rd_en(rd_en),
    .bypass(bypass), .count(count));

  replay_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .waddr(waddr), .din(din),
    .rd_en(rd_en), .bypass(bypass), .raddr(raddr), .dout(dout));

  replay_fifo_flags #(.DEPTH(DEPTH)) u_flags (.count(count), .flags(flags));

  assign empty_n = flags.empty_n;
  assign half_n  = flags.half_n;
  assign full_n  = flags.full_n;

  // R3
  flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!full_n |-> !half_n) && !(!empty_n && !half_n));
  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!empty_n && !wr_en && !rd_en) |=> $stable(dout));
endmodule

// File: tb/sim_replay_fifo.sv
`timescale 1ns/1ps
module sim_replay_fifo;
  localparam int DEPTH = 2048;
  localparam int HALF  = DEPTH / 2;

  logic clk, rst_n, wr_n, rd_n, rt_n;
  logic [8:0] din, dout;
  logic empty_n, half_n, full_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  replay_fifo u0 (.clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .empty_n(empty_n), .half_n(half_n), .full_n(full_n));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {op[1:0], din[8:0], exp dout[8:0], exp {empty_n,half_n,full_n}}
  // op 0 write, 1 read, 2 read+write, 3 rewind
  localparam logic [22:0] VEC [0:12] = '{
    {2'd0, 9'h011, 9'h000, 3'b111},
    {2'd0, 9'h022, 9'h000, 3'b111},
    {2'd0, 9'h133, 9'h000, 3'b111},
    {2'd1, 9'h000, 9'h011, 3'b111},
    {2'd2, 9'h044, 9'h022, 3'b111},
    {2'd1, 9'h000, 9'h133, 3'b111},
    {2'd1, 9'h000, 9'h044, 3'b011},
    {2'd1, 9'h000, 9'h044, 3'b011},
    {2'd3, 9'h000, 9'h044, 3'b111},
    {2'd1, 9'h000, 9'h011, 3'b111},
    {2'd1, 9'h000, 9'h022, 3'b111},
    {2'd1, 9'h000, 9'h133, 3'b111},
    {2'd1, 9'h000, 9'h044, 3'b011}
  };

  logic [8:0] hist [0:DEPTH-1];
  int wc, rc;
  logic [8:0] last;

  task automatic check(input string req, input logic [8:0] ed, input logic [2:0] ef);
    n_cmp++;
    if (dout !== ed || {empty_n, half_n, full_n} !== ef) begin
      n_bad++;
      $display("FAIL %s: dout=%h flags=%b expected dout=%h flags=%b",
               req, dout, {empty_n, half_n, full_n}, ed, ef);
    end
  endtask

  function automatic logic [2:0] mflags();
    int occ = wc - rc;
    return {occ != 0, !(occ > HALF), occ != DEPTH};
  endfunction

  task automatic strobe(input logic w, input logic r, input logic t, input logic [8:0] d);
    @(negedge clk);
    wr_n = ~w; rd_n = ~r; rt_n = ~t; din = d;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wc = 0; rc = 0; last = '0;
  endtask

  task automatic mwrite(input logic [8:0] d, input string req);
    strobe(1'b1, 1'b0, 1'b0, d);
    if (wc - rc < DEPTH) begin hist[wc] = d; wc++; end
    check(req, last, mflags());
  endtask

  task automatic mread(input string req);
    strobe(1'b0, 1'b1, 1'b0, '0);
    if (wc - rc > 0) begin last = hist[rc]; rc++; end
    check(req, last, mflags());
  endtask

  initial begin
    do_reset();
    check("R1", 9'h000, 3'b011);

    // table walk: R2 order, R11 simultaneous, R6 blocked read, R8 rewind
    for (int i = 0; i < 13; i++) begin
      logic [22:0] v = VEC[i];
      case (v[22:21])
        2'd0: strobe(1'b1, 1'b0, 1'b0, v[20:12]);
        2'd1: strobe(1'b0, 1'b1, 1'b0, '0);
        2'd2: strobe(1'b1, 1'b1, 1'b0, v[20:12]);
        default: strobe(1'b0, 1'b0, 1'b1, '0);
      endcase
      check($sformatf("R2/R8/R11 vec%0d", i), v[11:3], v[2:0]);
    end

    // R1: reset clears a non-empty buffer
    do_reset();
    check("R1", 9'h000, 3'b011);

    // R7: write held low for several cycles stores one word
    @(negedge clk); wr_n = 1'b0; din = 9'h0A5;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    hist[wc] = 9'h0A5; wc++;
    check("R7", last, mflags());
    mread("R2");
    mread("R6");

    // R10: read held low while empty, then writes
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); wr_n = 1'b0; din = 9'h1C3;
    @(negedge clk); wr_n = 1'b1;
    hist[wc] = 9'h1C3; wc++; rc++; last = 9'h1C3;
    check("R10 flow", last, 3'b011);
    @(negedge clk); wr_n = 1'b0; din = 9'h05A;
    @(negedge clk); wr_n = 1'b1;
    hist[wc] = 9'h05A; wc++;
    check("R10 second", 9'h1C3, 3'b111);
    @(negedge clk); rd_n = 1'b1;
    mread("R10 fresh read");

    // R11: simultaneous read and write
    mwrite(9'h101, "R11");
    mwrite(9'h102, "R11");
    strobe(1'b1, 1'b1, 1'b0, 9'h103);
    hist[wc] = 9'h103; wc++; last = hist[rc]; rc++;
    check("R11", last, mflags());
    mread("R11");
    mread("R11");

    // R9: rewind while read strobe low is ignored
    mwrite(9'h0F0, "R9");
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
    @(negedge clk); rd_n = 1'b1;
    last = hist[rc]; rc++;
    check("R9", last, mflags());

    // R8: rewind replays from address zero
    strobe(1'b0, 1'b0, 1'b1, '0);
    rc = 0;
    check("R8", last, mflags());
    mread("R8");

    // fill to full: R3, R4, R5, then rewind from full (R8) and read back (R2)
    do_reset();
    for (int i = 0; i < HALF; i++) mwrite(9'((i * 37) ^ 9'h055), "R3");
    mwrite(9'h1AA, "R4 rise");
    for (int i = HALF + 1; i < DEPTH; i++) mwrite(9'((i * 37) ^ 9'h055), "R3");
    check("R3 full", last, 3'b100);
    mwrite(9'h1FF, "R5");
    for (int i = 0; i < HALF; i++) mread("R2");
    check("R4 fall", last, 3'b111);
    strobe(1'b0, 1'b0, 1'b1, '0);
    rc = 0;
    check("R8 from full", last, 3'b100);
    for (int i = 0; i < DEPTH; i++) mread("R2 R5");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule